// File: doc/BRIEF.md
# Bulk IN Transmit FIFO with Packet Replay

This block holds the outgoing data of one bulk IN endpoint between the processor (or a DMA engine) and the protocol engine that serializes packets onto the bus. The writer pushes bytes over a valid/ready stream. It closes a frame either by raising a tag that travels with a byte, or by pulsing a separate end-of-frame command. Every stored entry keeps its own packet-end flag. A frame that has nothing pending when it is closed becomes a flag-only zero-length entry.

The protocol engine pulls one packet at a time over a second valid/ready stream. A packet ends at the first tagged byte or after `MAX_PKT` bytes, whichever comes first. After the last beat of a packet the engine reports one of two results. An acknowledge releases the packet's storage and moves on to the next packet. A failure rewinds the read position to the packet's first entry, so the same bytes are sent again. An IN token is answered with NAK while no closed packet is waiting.

Back-pressure rules: the writer must hold `wr_valid`, `wr_data`, `wr_last` and `eof_cmd` steady until `wr_ready` is high at a clock edge. The engine may hold `rd_ready` low for any number of cycles, and the offered beat stays unchanged while it does. Entries sent but not yet acknowledged still count as occupied.

Top module: `bulkin_resend_fifo`

## Requirements
- R1: After reset the FIFO is empty: `wr_ready`=1, `rd_valid`=0, `pkt_ready`=0.
- R2: A byte is stored on each clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly while `DEPTH` entries are held, counting entries that were sent but are unacknowledged.
- R3: A packet ends at its first tagged entry, or after `MAX_PKT` bytes if no tag comes first. `rd_last`=1 on that final beat.
- R4: A byte is tagged when it is written with `wr_last`=1, or with `eof_cmd`=1 in the same beat.
- R5: A pulse of `eof_cmd` with `wr_valid`=0, while bytes are written but not yet closed into a packet, tags the most recently written byte.
- R6: A pulse of `eof_cmd` with `wr_valid`=0 while no bytes are open stores a zero-length entry. That entry is offered as one beat with `rd_zlp`=1 and `rd_last`=1. The request is dropped if the FIFO is full.
- R7: `pkt_ready` is high while at least one closed packet is unacknowledged. `tok_nak` = `tok_in` AND NOT `pkt_ready`.
- R8: `rd_valid` is high only while `pkt_ready` is high and the current packet is not fully sent. A beat held under back-pressure keeps `rd_data`, `rd_last` and `rd_zlp` stable. After the final beat, `rd_valid` stays low until `pkt_ack` or `pkt_fail`.
- R9: `pkt_fail`, given at any point in a packet, returns the read position to the packet's first entry. The packet is then offered again from its first byte.
- R10: `pkt_ack` after the final beat frees the packet's entries and moves to the next packet. `pkt_ack` before the final beat has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Writer offers a byte |
| wr_ready | output | 1 | FIFO can take a byte |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Tag: this byte ends the frame (DMA side) |
| eof_cmd | input | 1 | End-of-frame command (register side); alone it tags the last byte or requests a zero-length packet |
| rd_valid | output | 1 | A beat of the current packet is offered |
| rd_ready | input | 1 | Engine takes the beat |
| rd_data | output | 8 | Byte of the current beat |
| rd_last | output | 1 | Beat is the final one of the packet |
| rd_zlp | output | 1 | Beat is a zero-length packet marker (no data) |
| pkt_ack | input | 1 | Packet delivered; release it |
| pkt_fail | input | 1 | Packet lost; replay from its first byte |
| pkt_ready | output | 1 | A complete packet is waiting |
| tok_in | input | 1 | IN token arrived for this endpoint |
| tok_nak | output | 1 | Token must be answered with NAK |

## Verification
The checker watches the read stream on every cycle. It confirms that beats appear only while a complete packet waits, that a stalled beat holds steady, that nothing follows a final beat until a result arrives, that no packet runs past `MAX_PKT` beats without `rd_last`, and that zero-length markers are always final. Byte order, the replay of the same bytes after a failure, tagging by the lone command, dropping a zero-length request while full, and storage release only on a valid acknowledge are data-dependent. Only the bench scenarios, which compare the bytes read against the bytes written, can show them.

// File: rtl/bulkin_pkg.sv
package bulkin_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              zlp;   // flag-only zero-length entry
    logic              last;  // entry closes its packet
    logic [DATA_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/bulkin_store.sv
module bulkin_store
  import bulkin_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  entry_t        wr_entry,
  input  logic          tag_en,
  input  logic [AW-1:0] tag_addr,
  input  logic [AW-1:0] rd_addr,
  output entry_t        rd_entry
);
  entry_t mem [DEPTH];

  // one write port plus a tag-only port; the write controller never
  // drives both in the same cycle
  always_ff @(posedge clk) begin
    if (wr_en)
      mem[wr_addr] <= wr_entry;
    else if (tag_en)
      mem[tag_addr].last <= 1'b1;
  end

  assign rd_entry = mem[rd_addr];
endmodule

// File: rtl/bulkin_wr_ctrl.sv
module bulkin_wr_ctrl
  import bulkin_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_PKT = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int SW = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              eof_cmd,
  input  logic [PW-1:0]     rd_base,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output entry_t            mem_wentry,
  output logic              tag_en,
  output logic [AW-1:0]     tag_addr,
  output logic              close_pkt
);
  logic [PW-1:0] wr_ptr;
  logic [SW-1:0] seg_cnt;   // bytes written since the last packet boundary
  logic [PW-1:0] used;
  logic          full, fire, beat_tag, seg_full, lone_eof, retag, zlp_wr, beat_close;

  assign used      = wr_ptr - rd_base;
  assign full      = (used == PW'(DEPTH));
  assign wr_ready  = ~full;
  assign fire      = wr_valid & ~full;
  assign beat_tag  = wr_last | eof_cmd;
  assign seg_full  = (seg_cnt == SW'(MAX_PKT - 1));
  assign lone_eof  = eof_cmd & ~wr_valid;
  assign retag     = lone_eof & (seg_cnt != '0);
  assign zlp_wr    = lone_eof & (seg_cnt == '0) & ~full;
  assign beat_close = fire & (beat_tag | seg_full);

  assign mem_we    = fire | zlp_wr;
  assign mem_waddr = wr_ptr[AW-1:0];
  always_comb begin
    if (fire) begin
      mem_wentry.zlp  = 1'b0;
      mem_wentry.last = beat_tag | seg_full;
      mem_wentry.data = wr_data;
    end else begin
      mem_wentry.zlp  = 1'b1;
      mem_wentry.last = 1'b1;
      mem_wentry.data = '0;
    end
  end

  assign tag_en    = retag;
  assign tag_addr  = AW'(wr_ptr - PW'(1));
  assign close_pkt = beat_close | retag | zlp_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      seg_cnt <= '0;
    end else begin
      if (mem_we)
        wr_ptr <= wr_ptr + PW'(1);
      if (fire)
        seg_cnt <= beat_close ? '0 : seg_cnt + SW'(1);
      else if (retag)
        seg_cnt <= '0;
    end
  end
endmodule

// File: rtl/bulkin_rd_ctrl.sv
module bulkin_rd_ctrl
  import bulkin_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_pkt,
  input  entry_t            rd_entry,
  output logic [AW-1:0]     rd_addr,
  output logic [PW-1:0]     rd_base,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              rd_zlp,
  input  logic              pkt_ack,
  input  logic              pkt_fail,
  output logic              pkt_ready
);
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] pend_cnt;  // closed packets not yet acknowledged
  logic          sent;      // final beat of current packet taken
  logic          beat, ack_ok, release_pkt;

  assign pkt_ready   = (pend_cnt != '0);
  assign rd_valid    = pkt_ready & ~sent;
  assign rd_addr     = rd_ptr[AW-1:0];
  assign rd_data     = rd_entry.data;
  assign rd_last     = rd_entry.last;
  assign rd_zlp      = rd_entry.zlp;
  assign beat        = rd_valid & rd_ready;
  assign ack_ok      = pkt_ack & sent;
  assign release_pkt = ack_ok & ~pkt_fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rd_base  <= '0;
      pend_cnt <= '0;
      sent     <= 1'b0;
    end else begin
      pend_cnt <= pend_cnt + PW'(close_pkt) - PW'(release_pkt);
      if (pkt_fail) begin
        rd_ptr <= rd_base;
        sent   <= 1'b0;
      end else if (ack_ok) begin
        rd_base <= rd_ptr;
        sent    <= 1'b0;
      end else if (beat) begin
        rd_ptr <= rd_ptr + PW'(1);
        if (rd_entry.last)
          sent <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bulkin_resend_fifo.sv
module bulkin_resend_fifo
  import bulkin_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_PKT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              eof_cmd,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              rd_zlp,
  input  logic              pkt_ack,
  input  logic              pkt_fail,
  output logic              pkt_ready,
  input  logic              tok_in,
  output logic              tok_nak
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          mem_we, tag_en, close_pkt;
  logic [AW-1:0] mem_waddr, tag_addr, rd_addr;
  logic [PW-1:0] rd_base;
  entry_t        mem_wentry, rd_entry;

  bulkin_wr_ctrl #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_last(wr_last), .eof_cmd(eof_cmd), .rd_base(rd_base),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wentry(mem_wentry),
    .tag_en(tag_en), .tag_addr(tag_addr), .close_pkt(close_pkt)
  );

  bulkin_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(mem_we), .wr_addr(mem_waddr), .wr_entry(mem_wentry),
    .tag_en(tag_en), .tag_addr(tag_addr), .rd_addr(rd_addr), .rd_entry(rd_entry)
  );

  bulkin_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .close_pkt(close_pkt), .rd_entry(rd_entry),
    .rd_addr(rd_addr), .rd_base(rd_base),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last), .rd_zlp(rd_zlp),
    .pkt_ack(pkt_ack), .pkt_fail(pkt_fail), .pkt_ready(pkt_ready)
  );

  assign tok_nak = tok_in & ~pkt_ready;
endmodule

// File: rtl/bulkin_resend_fifo_chk.sv
module bulkin_resend_fifo_chk
  import bulkin_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_PKT = 8,
  localparam int SW = $clog2(MAX_PKT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_last,
  input logic              rd_zlp,
  input logic              pkt_fail,
  input logic              pkt_ready
);
  logic [SW-1:0] bcnt;  // beats taken in the current packet

  always_ff @(posedge clk) begin
    if (!rst_n)
      bcnt <= '0;
    else if (pkt_fail)
      bcnt <= '0;
    else if (rd_valid && rd_ready)
      bcnt <= rd_last ? '0 : bcnt + SW'(1);
  end

  a_r8_valid_needs_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> pkt_ready);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !pkt_fail) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_last) && $stable(rd_zlp)));

  a_r8_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last) |=> !rd_valid);

  a_r3_pkt_len: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && bcnt == SW'(MAX_PKT - 1)) |-> rd_last);

  a_r6_zlp_final: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_zlp) |-> (rd_last && bcnt == '0));
endmodule

bind bulkin_resend_fifo bulkin_resend_fifo_chk #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_last(rd_last), .rd_zlp(rd_zlp),
  .pkt_fail(pkt_fail), .pkt_ready(pkt_ready)
);

// File: tb/bulkin_resend_fifo_tb.sv
`timescale 1ns/1ps
module bulkin_resend_fifo_tb;
  localparam int DEPTH = 16;
  localparam int MAX_PKT = 4;
  // vector: data[10:3], wr_last[2], eof_cmd with beat[1], expected rd_last[0]
  localparam int NV = 11;
  localparam logic [10:0] VEC [NV] = '{
    11'h080, 11'h088, 11'h095,
    11'h100, 11'h108, 11'h110, 11'h119,
    11'h180, 11'h188, 11'h191,
    11'h203 };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_last = 0, eof_cmd = 0, rd_ready = 0;
  logic pkt_ack = 0, pkt_fail = 0, tok_in = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, rd_valid, rd_last, rd_zlp, pkt_ready, tok_nak;
  logic [7:0] rd_data;
  int checks = 0, failures = 0;
  logic [7:0] gd; logic gl, gz;

  always #2.5 clk = ~clk;

  bulkin_resend_fifo #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .eof_cmd(eof_cmd),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_last(rd_last), .rd_zlp(rd_zlp), .pkt_ack(pkt_ack),
    .pkt_fail(pkt_fail), .pkt_ready(pkt_ready), .tok_in(tok_in), .tok_nak(tok_nak));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic push(input logic [7:0] d, input logic l, input logic e);
    @(negedge clk);
    wr_valid = 1; wr_data = d; wr_last = l; eof_cmd = e;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 0; wr_last = 0; eof_cmd = 0;
  endtask

  task automatic pop(output logic [7:0] d, output logic l, output logic z);
    @(negedge clk); rd_ready = 1;
    while (!rd_valid) @(negedge clk);
    d = rd_data; l = rd_last; z = rd_zlp;
    @(posedge clk); #1 rd_ready = 0;
  endtask

  task automatic lone_eof();
    @(negedge clk); eof_cmd = 1; @(posedge clk); #1 eof_cmd = 0;
  endtask
  task automatic ack();
    @(negedge clk); pkt_ack = 1; @(posedge clk); #1 pkt_ack = 0;
  endtask
  task automatic fail();
    @(negedge clk); pkt_fail = 1; @(posedge clk); #1 pkt_fail = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 wr_ready", wr_ready, 1);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 pkt_ready", pkt_ready, 0);

    // table walk: tags by wr_last (R4), size slicing (R3), lone eof (R5), eof with beat (R4)
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][10:3], VEC[i][2], VEC[i][1]);
      if (i == 9) lone_eof();
    end
    for (int i = 0; i < NV; i++) begin
      pop(gd, gl, gz);
      check("R3 data", gd, VEC[i][10:3]);
      check("R4 last", gl, VEC[i][0]);
      if (gl) ack();
    end
    @(negedge clk);
    check("R10 empty after acks", pkt_ready, 0);

    // R7: NAK until a packet closes; R5 lone eof tags
    tok_in = 1;
    @(negedge clk);
    check("R7 nak empty", tok_nak, 1);
    push(8'h50, 0, 0); push(8'h51, 0, 0);
    @(negedge clk);
    check("R7 open bytes not ready", pkt_ready, 0);
    check("R7 nak open", tok_nak, 1);
    lone_eof();
    @(negedge clk);
    check("R7 ready", pkt_ready, 1);
    check("R7 no nak", tok_nak, 0);
    tok_in = 0;
    pop(gd, gl, gz); check("R5 first", {gd, gl}, {8'h50, 1'b0});
    pop(gd, gl, gz); check("R5 tagged", {gd, gl}, {8'h51, 1'b1});
    ack();

    // R9 replay, R8 back-pressure
    push(8'h60, 0, 0); push(8'h61, 0, 0); push(8'h62, 1, 0);
    pop(gd, gl, gz); pop(gd, gl, gz);
    check("R9 before fail", gd, 8'h61);
    fail();
    pop(gd, gl, gz); check("R9 replay mid", gd, 8'h60);
    @(negedge clk); gd = rd_data;
    @(negedge clk);
    check("R8 stall valid", rd_valid, 1);
    check("R8 stall data", rd_data, gd);
    check("R8 stall byte", gd, 8'h61);
    pop(gd, gl, gz); pop(gd, gl, gz);
    check("R8 last beat", {gd, gl}, {8'h62, 1'b1});
    @(negedge clk);
    check("R8 quiet after last", rd_valid, 0);
    fail();
    for (int i = 0; i < 3; i++) begin
      pop(gd, gl, gz);
      check("R9 full replay", {gd, gl}, {8'h60 + 8'(i), i == 2});
    end
    ack();
    @(negedge clk);
    check("R10 released", pkt_ready, 0);

    // R6 zero-length packet after a full chunk
    for (int i = 0; i < 4; i++) push(8'h70 + 8'(i), 0, 0);
    lone_eof();
    for (int i = 0; i < 4; i++) begin
      pop(gd, gl, gz);
      check("R3 size slice", {gd, gl, gz}, {8'h70 + 8'(i), i == 3, 1'b0});
    end
    ack();
    pop(gd, gl, gz);
    check("R6 zlp beat", {gl, gz}, 2'b11);
    ack();
    @(negedge clk);
    check("R6 zlp consumed", pkt_ready, 0);

    // R2 full, R6 dropped when full, R10 premature ack ignored
    do_reset();
    for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(i), 0, 0);
    @(negedge clk);
    check("R2 full", wr_ready, 0);
    lone_eof();
    ack();
    @(negedge clk);
    check("R10 early ack ignored", wr_ready, 0);
    check("R10 still ready", pkt_ready, 1);
    for (int p = 0; p < DEPTH / MAX_PKT; p++) begin
      for (int i = 0; i < MAX_PKT; i++) begin
        pop(gd, gl, gz);
        check("R2 order", {gd, gl}, {8'h80 + 8'(p * MAX_PKT + i), i == MAX_PKT - 1});
      end
      ack();
      if (p == 0) begin
        @(negedge clk);
        check("R10 ack frees space", wr_ready, 1);
      end
    end
    @(negedge clk);
    check("R6 dropped while full", pkt_ready, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule